// File: doc/BRIEF.md
# Coded Serial Clock Prescaler

This block derives a serial bit clock from a parent clock. A 16-bit select word sets the division ratio. Its high byte either leaves the parent clock alone or applies a fixed pre-divide by 32. Its low byte carries a power-of-two divide code. One reserved word gives a bypass, which is a ratio of 1.

The block has two channels, one for transmit and one for receive. Each channel has its own select input, and software normally drives both with the same value. Each channel produces two outputs for a frame engine:

- a one-cycle tick, once per output period;
- a serial clock with 50% duty.

The block implements only the encoding and the resulting division. Choosing the ratio is left to software. Software picks the smallest supported ratio that is at least the parent-to-target ratio. It uses 1024 when no ratio is large enough.

Top module: `spi_clk_prescaler`

## Requirements
- R1: While `rst_ni` is low, every tick and serial clock output is 0. At the first rising clock edge after reset is released, each channel wraps and adopts its select word, so its tick output is 1 in that cycle.
- R2: Select word 0x0007 is bypass (ratio 1). In bypass the tick is 1 in every cycle and the serial clock output equals the parent clock.
- R3: A high byte of 0x00 with a low byte of 0 to 4 gives ratios of 2, 4, 8, 16 and 32.
- R4: A high byte of 0x1F with a low byte of 0 to 4 gives ratios of 64, 128, 256, 512 and 1024.
- R5: Every other select word gives a ratio of 1024. Examples are a low byte of 5, 6 or above 7, and any high byte other than 0x00 or 0x1F.
- R6: A new select word takes effect only at the end of the current output period. A period that is in progress always completes at its old length.
- R7: For a ratio N of 2 or more, the tick is 1 for exactly one cycle in every N. The serial clock is low for the first N/2 cycles of a period and high for the last N/2. It is low in the cycle that follows each tick edge.
- R8: The transmit and receive channels run independently. Changing one channel's select word never alters the other channel's period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parent clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_sel_i | input | 16 | Transmit select word |
| rx_sel_i | input | 16 | Receive select word |
| tx_tick_o | output | 1 | Transmit period tick |
| tx_sck_o | output | 1 | Transmit serial clock |
| rx_tick_o | output | 1 | Receive period tick |
| rx_sck_o | output | 1 | Receive serial clock |

## Verification
Ticks and serial clock levels are registered. They change on the rising edge at which the divider counter wraps or reaches its half point. The bench samples them at the following falling edge.

A select word driven at a falling edge is first seen at the next wrap edge. Its new ratio is therefore measured from the tick of that wrap to the next tick. The R6 case counts the whole period during which the word changed.

A behavioural model follows a phase counter and a ratio on every rising edge. Both channels are compared against it at every falling edge.

// File: rtl/spi_psc_pkg.sv
package spi_psc_pkg;
  localparam int              SEL_W    = 16;
  localparam logic [7:0]      PRE_CODE = 8'h1F;
  localparam int              PRE_LOG2 = 5;
  localparam int              MAX_CODE = 4;
  localparam logic [15:0]     BYP_SEL  = 16'h0007;
  localparam int              N_CH     = 2;
  localparam int              CH_TX    = 0;
  localparam int              CH_RX    = 1;
endpackage

// File: rtl/spi_psc_sel_decode.sv
module spi_psc_sel_decode #(
  parameter int              SEL_W    = 16,
  parameter logic [7:0]      PRE_CODE = 8'h1F,
  parameter int              PRE_LOG2 = 5,
  parameter int              MAX_CODE = 4,
  parameter logic [15:0]     BYP_SEL  = 16'h0007,
  parameter int              LOG_W    = 4
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [LOG_W-1:0] log_o
);
  localparam int HALF_W   = SEL_W / 2;
  localparam int FALLBACK = PRE_LOG2 + MAX_CODE + 1;

  logic [HALF_W-1:0] hi, lo;
  assign hi = sel_i[SEL_W-1:HALF_W];
  assign lo = sel_i[HALF_W-1:0];

  always_comb begin
    log_o = LOG_W'(FALLBACK);
    if (sel_i == SEL_W'(BYP_SEL)) begin
      log_o = '0;
    end else if (lo <= HALF_W'(MAX_CODE)) begin
      if (hi == '0)
        log_o = LOG_W'(int'(lo) + 1);
      else if (hi == HALF_W'(PRE_CODE))
        log_o = LOG_W'(int'(lo) + PRE_LOG2 + 1);
    end
  end
endmodule

// File: rtl/spi_psc_div_chan.sv
module spi_psc_div_chan #(
  parameter int LOG_W = 4,
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LOG_W-1:0] log_i,
  output logic             tick_o,
  output logic             sck_o,
  output logic             sckq_o,
  output logic [LOG_W-1:0] log_o
);
  logic [LOG_W-1:0] cur_log;
  logic [CNT_W-1:0] cnt, last, half_m1;
  logic [CNT_W:0]   span;
  logic             wrap, tick_q, sck_q, byp;

  assign span    = (CNT_W+1)'(1) << cur_log;
  assign last    = CNT_W'(span - (CNT_W+1)'(1));
  assign half_m1 = CNT_W'((span >> 1) - (CNT_W+1)'(1));
  assign wrap    = (cnt == last);
  assign byp     = (cur_log == '0);

  // reset to the last count of the longest ratio: the first edge wraps
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt     <= '1;
      cur_log <= LOG_W'(CNT_W);
      tick_q  <= 1'b0;
      sck_q   <= 1'b0;
    end else begin
      tick_q <= wrap;
      if (wrap) begin
        cnt     <= '0;
        cur_log <= log_i;
        sck_q   <= 1'b0;
      end else begin
        cnt <= cnt + CNT_W'(1);
        if (cnt == half_m1) sck_q <= 1'b1;
      end
    end
  end

  assign tick_o = tick_q;
  assign sckq_o = sck_q;
  assign sck_o  = byp ? clk_i : sck_q;
  assign log_o  = cur_log;
endmodule

// File: rtl/spi_clk_prescaler.sv
module spi_clk_prescaler
  import spi_psc_pkg::*;
#(
  parameter int          SEL_W_P    = SEL_W,
  parameter logic [7:0]  PRE_CODE_P = PRE_CODE,
  parameter int          PRE_LOG2_P = PRE_LOG2,
  parameter int          MAX_CODE_P = MAX_CODE
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SEL_W_P-1:0] tx_sel_i,
  input  logic [SEL_W_P-1:0] rx_sel_i,
  output logic               tx_tick_o,
  output logic               tx_sck_o,
  output logic               rx_tick_o,
  output logic               rx_sck_o
);
  localparam int MAX_LOG = PRE_LOG2_P + MAX_CODE_P + 1;
  localparam int LOG_W   = $clog2(MAX_LOG + 1);
  localparam int CNT_W   = MAX_LOG;

  logic [N_CH-1:0][SEL_W_P-1:0] sel_w;
  logic [N_CH-1:0][LOG_W-1:0]   dec_w, log_w;
  logic [N_CH-1:0]              tick_w, sck_w, sckq_w;

  assign sel_w[CH_TX] = tx_sel_i;
  assign sel_w[CH_RX] = rx_sel_i;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    spi_psc_sel_decode #(
      .SEL_W(SEL_W_P), .PRE_CODE(PRE_CODE_P), .PRE_LOG2(PRE_LOG2_P),
      .MAX_CODE(MAX_CODE_P), .BYP_SEL(BYP_SEL), .LOG_W(LOG_W)
    ) u_dec (
      .sel_i(sel_w[ch]),
      .log_o(dec_w[ch])
    );
    spi_psc_div_chan #(.LOG_W(LOG_W), .CNT_W(CNT_W)) u_div (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .log_i (dec_w[ch]),
      .tick_o(tick_w[ch]),
      .sck_o (sck_w[ch]),
      .sckq_o(sckq_w[ch]),
      .log_o (log_w[ch])
    );
  end

  assign tx_tick_o = tick_w[CH_TX];
  assign tx_sck_o  = sck_w[CH_TX];
  assign rx_tick_o = tick_w[CH_RX];
  assign rx_sck_o  = sck_w[CH_RX];
endmodule

// File: rtl/spi_clk_prescaler_chk.sv
module spi_clk_prescaler_chk #(
  parameter int LOG_W   = 4,
  parameter int MAX_LOG = 10,
  parameter int N_CH    = 2
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [N_CH-1:0]            tick_i,
  input logic [N_CH-1:0]            sckq_i,
  input logic [N_CH-1:0][LOG_W-1:0] log_i
);
  for (genvar ch = 0; ch < N_CH; ch++) begin : g_chk
    AST_BYP_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (log_i[ch] == '0) |-> tick_i[ch]);                              // R2
    AST_TICK_SCK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i[ch] && log_i[ch] != '0) |-> !sckq_i[ch]);               // R7
    AST_SCK_RISE_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sckq_i[ch]) |-> !tick_i[ch]);                             // R7
    AST_SWITCH_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(log_i[ch]) |-> tick_i[ch]);                            // R6
    AST_LOG_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      log_i[ch] <= LOG_W'(MAX_LOG));                                  // R5
  end
endmodule

bind spi_clk_prescaler spi_clk_prescaler_chk #(
  .LOG_W(LOG_W), .MAX_LOG(MAX_LOG), .N_CH(N_CH)
) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .tick_i(tick_w),
  .sckq_i(sckq_w),
  .log_i (log_w)
);

// File: tb/spi_clk_prescaler_tb.sv
`timescale 1ns/1ps
module spi_clk_prescaler_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] tx_sel_i = 16'h0002;
  logic [15:0] rx_sel_i = 16'h0004;
  logic        tx_tick_o, tx_sck_o, rx_tick_o, rx_sck_o;

  int n_chk = 0, n_fail = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  int m_ratio[2], m_pos[2];
  bit m_tick[2], m_sck[2];

  always #2.5 clk_i = ~clk_i;

  spi_clk_prescaler u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .tx_sel_i(tx_sel_i), .rx_sel_i(rx_sel_i),
    .tx_tick_o(tx_tick_o), .tx_sck_o(tx_sck_o),
    .rx_tick_o(rx_tick_o), .rx_sck_o(rx_sck_o)
  );

  function automatic int ratio_of(logic [15:0] sel);
    if (sel == 16'h0007) return 1;
    if (sel[15:8] == 8'h00 && sel[7:0] <= 8'd4) return 2 << sel[7:0];
    if (sel[15:8] == 8'h1F && sel[7:0] <= 8'd4) return 64 << sel[7:0];
    return 1024;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference: phase position within the current period
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < 2; c++) begin
        m_ratio[c] = 1024; m_pos[c] = 1023; m_tick[c] = 0; m_sck[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (m_pos[c] == m_ratio[c] - 1) begin
          m_tick[c]  = 1;
          m_pos[c]   = 0;
          m_sck[c]   = 0;
          m_ratio[c] = ratio_of(c == 0 ? tx_sel_i : rx_sel_i);
        end else begin
          m_tick[c] = 0;
          if (m_pos[c] == m_ratio[c] / 2 - 1) m_sck[c] = 1;
          m_pos[c]++;
        end
      end
    end
  end

  always @(negedge clk_i) begin
    if (cmp_en && rst_ni) begin
      chk("R7 tx tick vs model", int'(tx_tick_o), int'(m_tick[0]));
      chk("R7 rx tick vs model", int'(rx_tick_o), int'(m_tick[1]));
      chk("R7 tx sck vs model", int'(tx_sck_o), m_ratio[0] == 1 ? 0 : int'(m_sck[0]));
      chk("R7 rx sck vs model", int'(rx_sck_o), m_ratio[1] == 1 ? 0 : int'(m_sck[1]));
    end
  end

  function automatic logic tick_of(bit ch);
    return ch ? rx_tick_o : tx_tick_o;
  endfunction

  task automatic measure(bit ch, int exp, string req);
    int n = 0;
    do @(negedge clk_i); while (tick_of(ch) !== 1'b1);
    do begin @(negedge clk_i); n++; end while (tick_of(ch) !== 1'b1);
    chk(req, n, exp);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: outputs idle under reset
    chk("R1 tx tick in reset", int'(tx_tick_o), 0);
    chk("R1 tx sck in reset", int'(tx_sck_o), 0);
    chk("R1 rx tick in reset", int'(rx_tick_o), 0);
    chk("R1 rx sck in reset", int'(rx_sck_o), 0);
    rst_ni = 1'b1;
    cmp_en = 1'b1;
    @(negedge clk_i);
    chk("R1 tx wrap at first edge", int'(tx_tick_o), 1);
    chk("R1 rx wrap at first edge", int'(rx_tick_o), 1);
    chk("R1 tx sck low after wrap", int'(tx_sck_o), 0);
    // R8: tx 0x0002 -> 8, rx 0x0004 -> 32 concurrently
    measure(0, 8, "R8 tx period");
    measure(1, 32, "R8 rx period");

    for (int lo = 0; lo <= 4; lo++) begin
      tx_sel_i = 16'(lo);
      measure(0, 2 << lo, "R3 low code ratio");
    end

    tx_sel_i = 16'h0007;
    measure(0, 1, "R2 bypass period");
    @(posedge clk_i); #1;
    chk("R2 sck high with parent", int'(tx_sck_o), 1);
    chk("R2 tick each cycle", int'(tx_tick_o), 1);
    @(negedge clk_i); #0.5;
    chk("R2 sck low with parent", int'(tx_sck_o), 0);

    for (int lo = 0; lo <= 4; lo++) begin
      tx_sel_i = 16'h1F00 | 16'(lo);
      measure(0, 64 << lo, "R4 pre-divide ratio");
    end

    begin
      logic [15:0] bad[6] = '{16'h0005, 16'h0006, 16'h0008, 16'h0107, 16'h1F07, 16'h2000};
      foreach (bad[i]) begin
        tx_sel_i = bad[i];
        measure(0, 1024, "R5 unsupported code");
      end
    end

    // R6: change mid-period, old period must complete
    begin
      int n = 0;
      do @(negedge clk_i); while (tx_tick_o !== 1'b1);
      repeat (100) begin @(negedge clk_i); n++; end
      tx_sel_i = 16'h0001;
      do begin @(negedge clk_i); n++; end while (tx_tick_o !== 1'b1);
      chk("R6 old period completes", n, 1024);
      n = 0;
      do begin @(negedge clk_i); n++; end while (tx_tick_o !== 1'b1);
      chk("R6 new period after wrap", n, 4);
    end

    // R7: duty for ratio 8
    tx_sel_i = 16'h0002;
    measure(0, 8, "R7 period 8");
    begin
      int hi = 0, tk = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk_i);
        hi += int'(tx_sck_o);
        tk += int'(tx_tick_o);
        if (tx_tick_o) chk("R7 sck low at tick", int'(tx_sck_o), 0);
      end
      chk("R7 sck high cycles", hi, 4);
      chk("R7 one tick per period", tk, 1);
    end

    measure(1, 32, "R8 rx unaffected by tx");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule